// File: doc/BRIEF.md
# Two-Way Write-Back Data Cache with Line Maintenance Commands

This block is a small write-back data cache placed between a processor-side request port and a main-memory port that moves whole lines. It serves word loads and word stores. It also accepts line-level maintenance commands, which software uses to steer what the cache holds:

- fetch a line ahead of use;
- install a zeroed line without reading memory;
- discard a line without saving it;
- push a line out to memory;
- load a word while marking its line as the first candidate for eviction.

Each maintenance command carries an address and acts on the entire line that contains it. Storage is two-way set associative. Each set has one least-recently-used bit, and each line has a dirty bit. The processor side uses a valid/ready handshake and allows one request at a time. A request that hits, or that needs no memory traffic, completes with a response pulse one cycle after acceptance. A request that misses holds ready low until its memory work is done. The memory side holds a request until a one-cycle acknowledge arrives.

Top module: `cc_maint_cache`

## Requirements
- R1: Command encoding is 0 load, 1 store, 2 touch, 3 zero-allocate, 4 discard, 5 evict, 6 load-once, 7 no operation. A load that misses issues exactly one line read and returns the word addressed by bits [3:2]. Later loads to any word of that line hit, raise resp_valid one cycle after acceptance and cause no memory traffic. The memory request and its address stay stable until mem_ack.
- R2: A store that hits updates only its word and marks the line dirty, with no memory write. When a dirty line is chosen as a victim, the full line is written to memory before the replacement line is read.
- R3: A touch that misses reads the line into the cache and responds with resp_rdata zero. A later load to that line hits without a read. A touch to a resident line causes no memory traffic.
- R4: A zero-allocate never reads memory. Afterwards every word of the line reads zero and the line is dirty, so a later eviction writes zeros to memory. This also holds when the line was already resident with other data.
- R5: A discard removes the line without writing it back, even when it is dirty, so the next load returns the memory copy. A discard that misses responds one cycle after acceptance with no memory traffic.
- R6: An evict of a dirty line writes the line to memory and then invalidates it. An evict of a clean line invalidates it with no write. An evict that misses responds one cycle after acceptance with no traffic. After an evict, a load to the line misses.
- R7: On a miss, an invalid way in the set is filled first. When both ways are valid, the least recently accessed way is replaced.
- R8: A load-once returns the same data as a load, but its line becomes the next victim in its set.
- R9: While a miss is being serviced, req_ready stays low until the response is given.
- R10: After reset, req_ready is high, resp_valid and mem_req are low, and every line is invalid.
- R11: A way freed by an evict is the one used by the next allocation in that set, so the other resident line survives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request valid |
| req_ready | output | 1 | Cache can accept a request |
| req_cmd | input | 3 | Command code (see R1) |
| req_addr | input | ADDR_W (32) | Byte address |
| req_wdata | input | WORD_W (32) | Store data |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_rdata | output | WORD_W (32) | Load data; zero for other commands |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_we | output | 1 | 1 = line write, 0 = line read |
| mem_addr | output | ADDR_W (32) | Line-aligned memory address |
| mem_wdata | output | LINE_W (128) | Line written back |
| mem_ack | input | 1 | One-cycle memory acknowledge |
| mem_rdata | input | LINE_W (128) | Line returned on a read acknowledge |

## Verification
The bench counts memory reads and writes around each command. This catches designs that would otherwise look correct:

- a zero-allocate that quietly fills the line from memory;
- a discard that writes dirty data back;
- an evict of a clean line that still writes.

Replacement is probed by building sets with two resident lines and then checking which line survives a third allocation. This shows a design that picks the most recent way, ignores the load-once hint, or evicts a valid line while a freed way sits empty. Writebacks are checked against memory contents word by word, so a writeback that is skipped, stale or partial is caught.

// File: rtl/cc_pkg.sv
package cc_pkg;
   localparam int unsigned CC_WAYS = 2;

   typedef enum logic [2:0] {
      CMD_LOAD  = 3'd0,
      CMD_STORE = 3'd1,
      CMD_TOUCH = 3'd2,
      CMD_ZERO  = 3'd3,
      CMD_DROP  = 3'd4,
      CMD_EVICT = 3'd5,
      CMD_LOAD1 = 3'd6,
      CMD_NOP   = 3'd7
   } cc_cmd_e;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_WBACK  = 2'd1,
      ST_FILL   = 2'd2,
      ST_REPLAY = 2'd3
   } cc_state_e;
endpackage

// File: rtl/cc_way_store.sv
module cc_way_store #(
   parameter  int SETS   = 16,
   parameter  int TAG_W  = 24,
   parameter  int LINE_W = 128,
   localparam int IDX_W  = $clog2(SETS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  rd_set,
   output logic [TAG_W-1:0]  rd_tag,
   output logic              rd_valid,
   output logic              rd_dirty,
   output logic [LINE_W-1:0] rd_line,
   input  logic              wr_meta,
   input  logic              wr_data,
   input  logic [IDX_W-1:0]  wr_set,
   input  logic [TAG_W-1:0]  wr_tag,
   input  logic              wr_valid,
   input  logic              wr_dirty,
   input  logic [LINE_W-1:0] wr_line
);
   logic [TAG_W-1:0]  tag_q  [SETS];
   logic [LINE_W-1:0] line_q [SETS];
   logic [SETS-1:0]   vld_q;
   logic [SETS-1:0]   dty_q;

   assign rd_tag   = tag_q[rd_set];
   assign rd_valid = vld_q[rd_set];
   assign rd_dirty = dty_q[rd_set];
   assign rd_line  = line_q[rd_set];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= '0;
         dty_q <= '0;
      end else if (wr_meta) begin
         vld_q[wr_set] <= wr_valid;
         dty_q[wr_set] <= wr_dirty;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_meta) tag_q[wr_set] <= wr_tag;
      if (wr_data) line_q[wr_set] <= wr_line;
   end
endmodule

// File: rtl/cc_repl.sv
module cc_repl #(
   parameter  int SETS  = 16,
   localparam int IDX_W = $clog2(SETS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] q_set,
   input  logic [1:0]       q_valid,
   output logic             q_victim,
   input  logic             upd_en,
   input  logic [IDX_W-1:0] upd_set,
   input  logic             upd_way,
   input  logic             upd_once
);
   logic [SETS-1:0] evict_q;   // per set: way to replace next

   always_comb begin
      if (!q_valid[0])      q_victim = 1'b0;
      else if (!q_valid[1]) q_victim = 1'b1;
      else                  q_victim = evict_q[q_set];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) evict_q <= '0;
      else if (upd_en) evict_q[upd_set] <= upd_once ? upd_way : ~upd_way;
   end

   // R8: a load-once or freed way becomes the next victim of its set
   a_r8_once_victim: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && upd_once) |=> evict_q[$past(upd_set)] == $past(upd_way));
   // R7: an ordinary access leaves the other way as victim
   a_r7_lru_other: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && !upd_once) |=> evict_q[$past(upd_set)] != $past(upd_way));
endmodule

// File: rtl/cc_maint_cache.sv
module cc_maint_cache
   import cc_pkg::*;
#(
   parameter  int ADDR_W     = 32,
   parameter  int WORD_W     = 32,
   parameter  int LINE_WORDS = 4,
   parameter  int SETS       = 16,
   localparam int LINE_W     = WORD_W * LINE_WORDS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [2:0]        req_cmd,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [WORD_W-1:0] req_wdata,
   output logic              resp_valid,
   output logic [WORD_W-1:0] resp_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [LINE_W-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic [LINE_W-1:0] mem_rdata
);
   localparam int BSEL_W = $clog2(WORD_W / 8);
   localparam int WSEL_W = $clog2(LINE_WORDS);
   localparam int OFF_W  = BSEL_W + WSEL_W;
   localparam int IDX_W  = $clog2(SETS);
   localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;

   if ((SETS & (SETS - 1)) != 0 || SETS < 2) begin : g_bad_sets
      $error("SETS must be a power of two, at least 2");
   end
   if ((LINE_WORDS & (LINE_WORDS - 1)) != 0 || LINE_WORDS < 2) begin : g_bad_line
      $error("LINE_WORDS must be a power of two, at least 2");
   end
   if (WORD_W % 8 != 0 || WORD_W < 16) begin : g_bad_word
      $error("WORD_W must be a whole number of bytes, at least 16 bits");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("address too narrow for the geometry");
   end

   function automatic logic [LINE_W-1:0] put_word(input logic [LINE_W-1:0] line,
                                                  input logic [WSEL_W-1:0] sel,
                                                  input logic [WORD_W-1:0] w);
      logic [LINE_W-1:0] r;
      r = line;
      r[sel*WORD_W +: WORD_W] = w;
      return r;
   endfunction

   cc_state_e         state_q, state_d;
   cc_cmd_e           sv_cmd;
   logic [ADDR_W-1:0] sv_addr;
   logic [WORD_W-1:0] sv_wdata;
   logic              sv_way;

   logic [ADDR_W-1:0] look_addr;
   logic [IDX_W-1:0]  look_set;
   logic [TAG_W-1:0]  look_tag;
   logic [WSEL_W-1:0] look_word;
   logic              unused_lo;

   assign look_addr = (state_q == ST_IDLE) ? req_addr : sv_addr;
   assign look_set  = look_addr[OFF_W +: IDX_W];
   assign look_tag  = look_addr[ADDR_W-1 -: TAG_W];
   assign look_word = look_addr[BSEL_W +: WSEL_W];
   assign unused_lo = ^look_addr[BSEL_W-1:0];

   logic [TAG_W-1:0]   w_tag  [CC_WAYS];
   logic [LINE_W-1:0]  w_line [CC_WAYS];
   logic [CC_WAYS-1:0] w_valid, w_dirty, w_hit;
   logic [CC_WAYS-1:0] wr_meta_v, wr_data_v;
   logic [TAG_W-1:0]   wr_tag;
   logic               wr_valid, wr_dirty;
   logic [LINE_W-1:0]  wr_line;

   for (genvar g = 0; g < CC_WAYS; g++) begin : g_way
      cc_way_store #(.SETS(SETS), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_store (
         .clk      (clk),
         .rst_n    (rst_n),
         .rd_set   (look_set),
         .rd_tag   (w_tag[g]),
         .rd_valid (w_valid[g]),
         .rd_dirty (w_dirty[g]),
         .rd_line  (w_line[g]),
         .wr_meta  (wr_meta_v[g]),
         .wr_data  (wr_data_v[g]),
         .wr_set   (look_set),
         .wr_tag   (wr_tag),
         .wr_valid (wr_valid),
         .wr_dirty (wr_dirty),
         .wr_line  (wr_line)
      );
      assign w_hit[g] = w_valid[g] && (w_tag[g] == look_tag);
   end

   logic hit_any, hit_way, victim;
   logic upd_en, upd_way, upd_once;
   assign hit_any = |w_hit;
   assign hit_way = w_hit[1];

   cc_repl #(.SETS(SETS)) u_repl (
      .clk      (clk),
      .rst_n    (rst_n),
      .q_set    (look_set),
      .q_valid  (w_valid),
      .q_victim (victim),
      .upd_en   (upd_en),
      .upd_set  (look_set),
      .upd_way  (upd_way),
      .upd_once (upd_once)
   );

   logic              act_way;
   logic [LINE_W-1:0] act_line;
   logic [WORD_W-1:0] act_word;
   logic              done, cap, cap_way;
   logic [WORD_W-1:0] done_data;
   cc_cmd_e           in_cmd;

   assign in_cmd   = cc_cmd_e'(req_cmd);
   assign act_way  = (state_q == ST_IDLE) ? hit_way : sv_way;
   assign act_line = w_line[act_way];
   assign act_word = act_line[look_word*WORD_W +: WORD_W];

   always_comb begin
      state_d   = state_q;
      wr_meta_v = '0;
      wr_data_v = '0;
      wr_tag    = look_tag;
      wr_valid  = 1'b1;
      wr_dirty  = 1'b0;
      wr_line   = act_line;
      upd_en    = 1'b0;
      upd_way   = act_way;
      upd_once  = 1'b0;
      done      = 1'b0;
      done_data = '0;
      cap       = 1'b0;
      cap_way   = victim;
      unique case (state_q)
         ST_IDLE: if (req_valid) begin
            unique case (in_cmd)
               CMD_LOAD, CMD_LOAD1, CMD_STORE, CMD_TOUCH, CMD_ZERO: begin
                  if (hit_any) begin
                     done   = 1'b1;
                     upd_en = 1'b1;
                     if (in_cmd == CMD_LOAD || in_cmd == CMD_LOAD1) begin
                        done_data = act_word;
                        upd_once  = (in_cmd == CMD_LOAD1);
                     end else if (in_cmd == CMD_STORE) begin
                        wr_meta_v[act_way] = 1'b1;
                        wr_data_v[act_way] = 1'b1;
                        wr_dirty = 1'b1;
                        wr_line  = put_word(act_line, look_word, req_wdata);
                     end else if (in_cmd == CMD_ZERO) begin
                        wr_meta_v[act_way] = 1'b1;
                        wr_data_v[act_way] = 1'b1;
                        wr_dirty = 1'b1;
                        wr_line  = '0;
                     end
                  end else begin
                     cap = 1'b1;
                     if (w_valid[victim] && w_dirty[victim]) state_d = ST_WBACK;
                     else if (in_cmd == CMD_ZERO)            state_d = ST_REPLAY;
                     else                                    state_d = ST_FILL;
                  end
               end
               CMD_DROP: begin
                  done = 1'b1;
                  if (hit_any) begin
                     wr_meta_v[act_way] = 1'b1;
                     wr_valid = 1'b0;
                     upd_en   = 1'b1;
                     upd_once = 1'b1;
                  end
               end
               CMD_EVICT: begin
                  if (hit_any && w_dirty[act_way]) begin
                     cap     = 1'b1;
                     cap_way = act_way;
                     state_d = ST_WBACK;
                  end else begin
                     done = 1'b1;
                     if (hit_any) begin
                        wr_meta_v[act_way] = 1'b1;
                        wr_valid = 1'b0;
                        upd_en   = 1'b1;
                        upd_once = 1'b1;
                     end
                  end
               end
               default: done = 1'b1;
            endcase
         end
         ST_WBACK: if (mem_ack) begin
            if (sv_cmd == CMD_EVICT) begin
               wr_meta_v[sv_way] = 1'b1;
               wr_valid = 1'b0;
               upd_en   = 1'b1;
               upd_once = 1'b1;
               done     = 1'b1;
               state_d  = ST_IDLE;
            end else if (sv_cmd == CMD_ZERO) begin
               state_d = ST_REPLAY;
            end else begin
               state_d = ST_FILL;
            end
         end
         ST_FILL: if (mem_ack) begin
            wr_meta_v[sv_way] = 1'b1;
            wr_data_v[sv_way] = 1'b1;
            wr_line = mem_rdata;
            state_d = ST_REPLAY;
         end
         ST_REPLAY: begin
            done    = 1'b1;
            upd_en  = 1'b1;
            state_d = ST_IDLE;
            unique case (sv_cmd)
               CMD_LOAD, CMD_LOAD1: begin
                  done_data = act_word;
                  upd_once  = (sv_cmd == CMD_LOAD1);
               end
               CMD_STORE: begin
                  wr_meta_v[sv_way] = 1'b1;
                  wr_data_v[sv_way] = 1'b1;
                  wr_dirty = 1'b1;
                  wr_line  = put_word(act_line, look_word, sv_wdata);
               end
               CMD_ZERO: begin
                  wr_meta_v[sv_way] = 1'b1;
                  wr_data_v[sv_way] = 1'b1;
                  wr_dirty = 1'b1;
                  wr_line  = '0;
               end
               default: ;
            endcase
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         sv_cmd     <= CMD_NOP;
         sv_addr    <= '0;
         sv_wdata   <= '0;
         sv_way     <= 1'b0;
         resp_valid <= 1'b0;
         resp_rdata <= '0;
      end else begin
         state_q    <= state_d;
         resp_valid <= done;
         resp_rdata <= done_data;
         if (cap) begin
            sv_cmd   <= in_cmd;
            sv_addr  <= req_addr;
            sv_wdata <= req_wdata;
            sv_way   <= cap_way;
         end
      end
   end

   assign req_ready = (state_q == ST_IDLE);
   assign mem_req   = (state_q == ST_WBACK) || (state_q == ST_FILL);
   assign mem_we    = (state_q == ST_WBACK);
   assign mem_addr  = (state_q == ST_WBACK) ? {w_tag[sv_way], look_set, {OFF_W{1'b0}}}
                                            : {look_tag, look_set, {OFF_W{1'b0}}};
   assign mem_wdata = w_line[sv_way];

   // R2: only a valid dirty line is ever written back
   a_r2_wback_dirty: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> (w_valid[sv_way] && w_dirty[sv_way]));
   // R4: a zero-allocate never reads memory
   a_r4_zero_no_read: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we) |-> (sv_cmd != CMD_ZERO));
   // R5: a discard never produces memory traffic
   a_r5_drop_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (sv_cmd != CMD_DROP));
   // R9: no new request is accepted while memory is busy
   a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !req_ready);
   // R1: memory request and address held until acknowledge
   a_r1_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
endmodule

// File: tb/tb_cc_maint_cache.sv
`timescale 1ns/1ps
module tb_cc_maint_cache;
   localparam int AW = 32;
   localparam int DW = 32;
   localparam int LW = 128;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [2:0]    req_cmd = 3'd0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          resp_valid;
   logic [DW-1:0] resp_rdata;
   logic          mem_req, mem_we;
   logic [AW-1:0] mem_addr;
   logic [LW-1:0] mem_wdata;
   logic          mem_ack = 1'b0;
   logic [LW-1:0] mem_rdata = '0;

   int checks = 0;
   int fails  = 0;
   int rd_cnt = 0;
   int wr_cnt = 0;
   int lat_c  = 0;
   logic [LW-1:0] mem [256];

   always #2 clk = ~clk;

   cc_maint_cache dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_cmd(req_cmd),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .resp_valid(resp_valid), .resp_rdata(resp_rdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
   );

   // behavioural memory, three cycles from request to acknowledge
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 256; i++)
            for (int j = 0; j < 4; j++)
               mem[i][j*32 +: 32] <= 32'hC0DE_0000 + i*16 + j*4;
         mem_ack <= 1'b0;
         lat_c   <= 0;
      end else begin
         mem_ack <= 1'b0;
         if (mem_req && !mem_ack) begin
            if (lat_c == 2) begin
               lat_c   <= 0;
               mem_ack <= 1'b1;
               if (mem_we) begin
                  mem[mem_addr[11:4]] <= mem_wdata;
                  wr_cnt <= wr_cnt + 1;
               end else begin
                  mem_rdata <= mem[mem_addr[11:4]];
                  rd_cnt <= rd_cnt + 1;
               end
            end else begin
               lat_c <= lat_c + 1;
            end
         end
      end
   end

   function automatic logic [31:0] pat(input logic [31:0] a);
      return 32'hC0DE_0000 + {20'd0, a[11:2], 2'b00};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // issue one request; returns data, latency in cycles, and whether ready rose early
   task automatic req(input logic [2:0] c, input logic [31:0] a, input logic [31:0] d,
                      output logic [31:0] q, output int lat, output bit leak);
      @(negedge clk);
      req_valid = 1'b1; req_cmd = c; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0;
      lat = 1; leak = 1'b0;
      while (!resp_valid && lat < 200) begin
         if (req_ready) leak = 1'b1;
         @(negedge clk);
         lat++;
      end
      q = resp_rdata;
   endtask

   task automatic t_reset();
      logic [31:0] q; int lat; bit lk; int r0;
      chk("R10 ready", {31'd0, req_ready}, 32'd1);
      chk("R10 resp_valid", {31'd0, resp_valid}, 32'd0);
      chk("R10 mem_req", {31'd0, mem_req}, 32'd0);
      r0 = rd_cnt;
      req(3'd0, 32'h0, 0, q, lat, lk);
      chk("R10 first load misses", rd_cnt - r0, 1);
   endtask

   task automatic t_load();
      logic [31:0] q; int lat; bit lk; int r0;
      r0 = rd_cnt;
      req(3'd0, 32'h074, 0, q, lat, lk);
      chk("R1 miss data", q, pat(32'h074));
      chk("R1 one read", rd_cnt - r0, 1);
      chk("R9 ready low during miss", {31'd0, lk}, 0);
      chk("R9 miss takes several cycles", {31'd0, lat > 3}, 1);
      req(3'd0, 32'h07C, 0, q, lat, lk);
      chk("R1 hit data", q, pat(32'h07C));
      chk("R1 hit latency", lat, 1);
      chk("R1 hit no read", rd_cnt - r0, 1);
   endtask

   task automatic t_store_lru();
      logic [31:0] q; int lat; bit lk; int r0, w0;
      w0 = wr_cnt;
      req(3'd1, 32'h008, 32'h55AA_1234, q, lat, lk);   // line 0x000 is resident
      chk("R2 store hit latency", lat, 1);
      req(3'd0, 32'h008, 0, q, lat, lk);
      chk("R2 store readback", q, 32'h55AA_1234);
      chk("R2 no write on store", wr_cnt - w0, 0);
      req(3'd0, 32'h100, 0, q, lat, lk);               // fills the other way
      r0 = rd_cnt;
      req(3'd0, 32'h200, 0, q, lat, lk);               // evicts 0x000 (LRU, dirty)
      chk("R2 writeback count", wr_cnt - w0, 1);
      chk("R2 fill after writeback", rd_cnt - r0, 1);
      chk("R2 stored word in memory", mem[0][64 +: 32], 32'h55AA_1234);
      chk("R2 other word in memory", mem[0][0 +: 32], pat(32'h000));
      chk("R7 new line data", q, pat(32'h200));
      r0 = rd_cnt;
      req(3'd0, 32'h100, 0, q, lat, lk);
      chk("R7 recent line kept", rd_cnt - r0, 0);
      req(3'd0, 32'h300, 0, q, lat, lk);               // evicts 0x200
      req(3'd0, 32'h100, 0, q, lat, lk);
      chk("R7 0x100 still resident", rd_cnt - r0, 1);
      req(3'd0, 32'h200, 0, q, lat, lk);
      chk("R7 LRU line was replaced", rd_cnt - r0, 2);
   endtask

   task automatic t_touch();
      logic [31:0] q; int lat; bit lk; int r0, w0;
      r0 = rd_cnt; w0 = wr_cnt;
      req(3'd2, 32'h010, 0, q, lat, lk);
      chk("R3 touch reads line", rd_cnt - r0, 1);
      chk("R3 touch no data", q, 0);
      req(3'd0, 32'h014, 0, q, lat, lk);
      chk("R3 load after touch", q, pat(32'h014));
      chk("R3 load after touch hits", lat, 1);
      req(3'd2, 32'h010, 0, q, lat, lk);
      chk("R3 touch resident no traffic", (rd_cnt - r0) + (wr_cnt - w0), 1);
   endtask

   task automatic t_zero();
      logic [31:0] q; int lat; bit lk; int r0, w0;
      r0 = rd_cnt; w0 = wr_cnt;
      req(3'd3, 32'h020, 0, q, lat, lk);
      chk("R4 zero alloc no read", rd_cnt - r0, 0);
      req(3'd0, 32'h02C, 0, q, lat, lk);
      chk("R4 zeroed word", q, 0);
      chk("R4 zeroed line hits", lat, 1);
      req(3'd5, 32'h020, 0, q, lat, lk);
      chk("R4 dirty zero written", wr_cnt - w0, 1);
      chk("R4 memory word0 zero", mem[2][0 +: 32], 0);
      chk("R4 memory word3 zero", mem[2][96 +: 32], 0);
      req(3'd0, 32'h420, 0, q, lat, lk);
      req(3'd1, 32'h424, 32'hFACE_0001, q, lat, lk);
      r0 = rd_cnt; w0 = wr_cnt;
      req(3'd3, 32'h420, 0, q, lat, lk);
      chk("R4 zero on hit no traffic", (rd_cnt - r0) + (wr_cnt - w0), 0);
      req(3'd0, 32'h424, 0, q, lat, lk);
      chk("R4 zero on hit clears data", q, 0);
   endtask

   task automatic t_drop();
      logic [31:0] q; int lat; bit lk; int r0, w0;
      req(3'd0, 32'h030, 0, q, lat, lk);
      req(3'd1, 32'h030, 32'hDEAD_0001, q, lat, lk);
      r0 = rd_cnt; w0 = wr_cnt;
      req(3'd4, 32'h030, 0, q, lat, lk);
      chk("R5 discard no write", wr_cnt - w0, 0);
      req(3'd0, 32'h030, 0, q, lat, lk);
      chk("R5 stale memory copy", q, pat(32'h030));
      chk("R5 reload reads", rd_cnt - r0, 1);
      req(3'd4, 32'h530, 0, q, lat, lk);
      chk("R5 discard miss latency", lat, 1);
      chk("R5 discard miss no traffic", (rd_cnt - r0) + (wr_cnt - w0), 1);
   endtask

   task automatic t_flush();
      logic [31:0] q; int lat; bit lk; int r0, w0;
      req(3'd0, 32'h040, 0, q, lat, lk);
      req(3'd1, 32'h040, 32'hBEEF_0002, q, lat, lk);
      r0 = rd_cnt; w0 = wr_cnt;
      req(3'd5, 32'h040, 0, q, lat, lk);
      chk("R6 dirty evict writes", wr_cnt - w0, 1);
      chk("R6 written data", mem[4][0 +: 32], 32'hBEEF_0002);
      req(3'd0, 32'h040, 0, q, lat, lk);
      chk("R6 load after evict misses", rd_cnt - r0, 1);
      chk("R6 reload data", q, 32'hBEEF_0002);
      req(3'd5, 32'h040, 0, q, lat, lk);
      chk("R6 clean evict no write", wr_cnt - w0, 1);
      req(3'd5, 32'h640, 0, q, lat, lk);
      chk("R6 evict miss latency", lat, 1);
      chk("R6 evict miss no traffic", (rd_cnt - r0) + (wr_cnt - w0), 2);
   endtask

   task automatic t_free();
      logic [31:0] q; int lat; bit lk; int r0;
      req(3'd0, 32'h050, 0, q, lat, lk);
      req(3'd0, 32'h150, 0, q, lat, lk);
      req(3'd5, 32'h150, 0, q, lat, lk);   // frees the recent way
      req(3'd0, 32'h250, 0, q, lat, lk);
      r0 = rd_cnt;
      req(3'd0, 32'h050, 0, q, lat, lk);
      chk("R11 older line survives", rd_cnt - r0, 0);
      chk("R11 older line data", q, pat(32'h050));
   endtask

   task automatic t_once();
      logic [31:0] q; int lat; bit lk; int r0;
      req(3'd0, 32'h060, 0, q, lat, lk);
      req(3'd0, 32'h160, 0, q, lat, lk);
      req(3'd6, 32'h168, 0, q, lat, lk);
      chk("R8 load-once data", q, pat(32'h168));
      chk("R8 load-once hit latency", lat, 1);
      req(3'd0, 32'h260, 0, q, lat, lk);   // must evict 0x160
      r0 = rd_cnt;
      req(3'd0, 32'h060, 0, q, lat, lk);
      chk("R8 older line kept", rd_cnt - r0, 0);
      req(3'd0, 32'h160, 0, q, lat, lk);
      chk("R8 hinted line evicted", rd_cnt - r0, 1);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_load();
      t_store_lru();
      t_touch();
      t_zero();
      t_drop();
      t_flush();
      t_free();
      t_once();
      repeat (4) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule